// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a three-wire serial audio stream (bit clock, word clock, data) into parallel 24-bit two's-complement samples in the system clock domain. The bit clock and word clock are oversampled by the system clock. Each rising bit-clock edge takes one data bit, most significant bit first. A change of the word-clock level marks the boundary between channel words.

Four static configuration pins choose the framing (I2S, left-justified, right-justified 16-bit or right-justified 24-bit). The same pins choose stereo or single-channel operation, the channel to keep in single-channel mode, and the rolloff select passed on to a downstream interpolation filter. One pin combination selects a filter-bypass framing. In that framing the word clock runs at a multiple of the sample rate, and each 24-bit word ends at a falling word-clock edge.

Results leave as a left/right sample pair with a one-cycle valid strobe. The configuration pins are expected to stay constant while reset is low; change them under reset.

Top module: `audio_serial_rx`

## Requirements
- R1: Each data bit is taken on a rising bit-clock edge, most significant bit first, and samples keep their two's-complement sign.
- R2: With format code 00 (I2S), word clock low carries the left word, and the word's first bit is taken on the second rising bit-clock edge after the word-clock change.
- R3: With format code 01 (left-justified), word clock high carries the left word, and the first bit is taken on the first rising edge after the word-clock change.
- R4: With format code 11 (right-justified 24-bit), word clock high carries the left word, and the word is the 24 bits taken on the edges just before the edge that first sees the changed word-clock level.
- R5: With format code 10 (right-justified 16-bit), the 16 bits before the word-clock change are the word, bit 15 is copied into bits 23:16, and earlier bits in the slot have no effect.
- R6: The format code is cfg_fmt_i[1:0]: 00 I2S, 01 left-justified, 10 right-justified 16-bit, 11 right-justified 24-bit.
- R7: With cfg_mono_i low, slow_rolloff_o follows cfg_chsel_i (0 sharp, 1 slow), except in bypass mode. With cfg_mono_i high, slow_rolloff_o is 0.
- R8: With cfg_mono_i high, only the channel selected by cfg_chsel_i (0 left, 1 right) is kept. It drives both outputs, with one valid strobe per frame.
- R9: cfg_mono_i=0, cfg_chsel_i=1, cfg_fmt_i=11 selects bypass mode. In this mode bypass_o=1 and slow_rolloff_o=0, and each 24-bit word whose last bit comes just before a falling word-clock edge appears on both outputs with its own strobe.
- R10: In stereo mode valid_o pulses for exactly one cycle per completed left-then-right pair. No word is emitted before the first word-clock change after reset.
- R11: During reset left_o, right_o and valid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (channel or word framing) |
| sdata_i | input | 1 | Serial data |
| cfg_mono_i | input | 1 | Single-channel mode select |
| cfg_chsel_i | input | 1 | Rolloff select (stereo) or channel select (mono) |
| cfg_fmt_i | input | 2 | Framing code |
| left_o | output | 24 | Left sample |
| right_o | output | 24 | Right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| slow_rolloff_o | output | 1 | Decoded rolloff select, 1 = slow |
| bypass_o | output | 1 | Filter-bypass framing active |

## Verification
In the right-justified framings, one bit event does two things at once. It closes the previous word on the word-clock change, and it shifts in the first bit of the next slot. The bench provokes this by filling the leading pad bits of every right-justified slot with ones, so the bit taken at the boundary edge is a 1. Expected samples in the scoreboard queue come from the bench's own words, so any pad bit that leaks into a captured word shows as a mismatch in the compared pair. Bypass words likewise start their slot with ones at the falling edge that ends the previous word.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    localparam int WORD_W  = 24;
    localparam int SHORT_W = 16;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LEFT = 2'b01,
        FMT_RJ16 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic mono;
        logic pick_right;
        logic slow;
        logic bypass;
    } mode_t;

    typedef struct packed {
        logic tick;
        logic din;
        logic ws;
    } bit_ev_t;

    function automatic mode_t decode_mode(input logic mono, input logic chsel,
                                          input logic [1:0] fmt);
        mode_t m;
        m.fmt        = fmt_e'(fmt);
        m.mono       = mono;
        m.bypass     = !mono && chsel && (fmt == 2'b11);
        m.pick_right = mono && chsel;
        m.slow       = !mono && chsel && !m.bypass;
        return m;
    endfunction

endpackage

// File: rtl/audrx_bitedge.sv
module audrx_bitedge
    import audrx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bclk_i,
    input  logic    wclk_i,
    input  logic    sdata_i,
    output bit_ev_t ev
);
    logic bclk_q, bclk_d, wclk_q, sd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            bclk_d <= 1'b0;
            wclk_q <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            bclk_d <= bclk_q;
            wclk_q <= wclk_i;
            sd_q   <= sdata_i;
        end
    end

    assign ev.tick = bclk_q && !bclk_d;
    assign ev.din  = sd_q;
    assign ev.ws   = wclk_q;

    assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (rst)
        ev.tick |=> !ev.tick);
endmodule

// File: rtl/audrx_frame.sv
module audrx_frame
    import audrx_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int SW = SHORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bit_ev_t      ev,
    input  mode_t        mode,
    output logic         word_stb,
    output logic         word_ch,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(2 * W);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] LAST_LJ  = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] LAST_I2S = CNT_W'(W);

    logic [W-1:0]     sr, sr_next, cap_word;
    logic [CNT_W-1:0] idx, cur_idx;
    logic             ws_last, primed, seen, ch_right;
    logic             edge_ws, lead_right, cap, cap_ch;

    assign sr_next    = {sr[W-2:0], ev.din};
    assign edge_ws    = primed && (ev.ws != ws_last);
    assign lead_right = (mode.fmt == FMT_I2S) ? ev.ws : !ev.ws;

    always_comb begin
        if (edge_ws)             cur_idx = '0;
        else if (idx == CNT_MAX) cur_idx = idx;
        else                     cur_idx = idx + 1'b1;
    end

    always_comb begin
        cap      = 1'b0;
        cap_ch   = ch_right;
        cap_word = sr_next;
        if (mode.bypass) begin
            cap      = edge_ws && seen && ws_last && !ev.ws;
            cap_ch   = 1'b0;
            cap_word = sr;
        end else begin
            unique case (mode.fmt)
                FMT_I2S:  cap = (cur_idx == LAST_I2S);
                FMT_LEFT: cap = (cur_idx == LAST_LJ);
                FMT_RJ24: begin
                    cap      = edge_ws && seen;
                    cap_ch   = !ws_last;
                    cap_word = sr;
                end
                FMT_RJ16: begin
                    cap      = edge_ws && seen;
                    cap_ch   = !ws_last;
                    cap_word = {{(W - SW){sr[SW-1]}}, sr[SW-1:0]};
                end
                default: cap = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            idx      <= CNT_MAX;
            ws_last  <= 1'b0;
            primed   <= 1'b0;
            seen     <= 1'b0;
            ch_right <= 1'b0;
            word_stb <= 1'b0;
            word_ch  <= 1'b0;
            word     <= '0;
        end else begin
            word_stb <= 1'b0;
            if (ev.tick) begin
                sr      <= sr_next;
                ws_last <= ev.ws;
                primed  <= 1'b1;
                idx     <= cur_idx;
                if (edge_ws) begin
                    seen     <= 1'b1;
                    ch_right <= lead_right;
                end
                if (cap) begin
                    word_stb <= 1'b1;
                    word_ch  <= cap_ch;
                    word     <= cap_word;
                end
            end
        end
    end

    assert_word_after_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> seen);

    assert_bypass_left_R9: assert property (@(posedge clk) disable iff (rst)
        (word_stb && mode.bypass) |-> !word_ch);
endmodule

// File: rtl/audrx_pair.sv
module audrx_pair
    import audrx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_t        mode,
    input  logic         word_stb,
    input  logic         word_ch,
    input  logic [W-1:0] word,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         valid_o
);
    logic [W-1:0] held;
    logic         have_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            have_left <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_stb) begin
                if (mode.bypass) begin
                    left_o  <= word;
                    right_o <= word;
                    valid_o <= 1'b1;
                end else if (mode.mono) begin
                    if (word_ch == mode.pick_right) begin
                        left_o  <= word;
                        right_o <= word;
                        valid_o <= 1'b1;
                    end
                end else if (!word_ch) begin
                    held      <= word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_o    <= held;
                    right_o   <= word;
                    valid_o   <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_mono_copy_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (mode.mono || mode.bypass)) |-> (left_o == right_o));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import audrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              wclk_i,
    input  logic              sdata_i,
    input  logic              cfg_mono_i,
    input  logic              cfg_chsel_i,
    input  logic [1:0]        cfg_fmt_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o,
    output logic              slow_rolloff_o,
    output logic              bypass_o
);
    mode_t             mode;
    bit_ev_t           ev;
    logic              word_stb, word_ch;
    logic [WORD_W-1:0] word;

    assign mode           = decode_mode(cfg_mono_i, cfg_chsel_i, cfg_fmt_i);
    assign slow_rolloff_o = mode.slow;
    assign bypass_o       = mode.bypass;

    audrx_bitedge u_edge (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .wclk_i  (wclk_i),
        .sdata_i (sdata_i),
        .ev      (ev)
    );

    audrx_frame #(.W(WORD_W), .SW(SHORT_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .mode     (mode),
        .word_stb (word_stb),
        .word_ch  (word_ch),
        .word     (word)
    );

    audrx_pair #(.W(WORD_W)) u_pair (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .word_stb (word_stb),
        .word_ch  (word_ch),
        .word     (word),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

    assert_bypass_sharp_R9: assert property (@(posedge clk) disable iff (rst)
        bypass_o |-> !slow_rolloff_o);

    assert_mono_sharp_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_mono_i |-> !slow_rolloff_o);

    assert_sign_ext_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && cfg_fmt_i == 2'b10) |->
        (($countones(left_o[WORD_W-1:SHORT_W-1]) == 0) ||
         ($countones(left_o[WORD_W-1:SHORT_W-1]) == WORD_W - SHORT_W + 1)));
endmodule

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;
    localparam int HB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
    logic        cfg_mono = 1'b0, cfg_chsel = 1'b0;
    logic [1:0]  cfg_fmt = 2'b00;
    logic [23:0] left_o, right_o;
    logic        valid_o, slow_o, bypass_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    audio_serial_rx u0 (
        .clk(clk), .rst(rst), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
        .cfg_mono_i(cfg_mono), .cfg_chsel_i(cfg_chsel), .cfg_fmt_i(cfg_fmt),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
        .slow_rolloff_o(slow_o), .bypass_o(bypass_o)
    );

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected pair L=%h R=%h expected none", left_o, right_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (left_o !== e.l || right_o !== e.r) begin
                    fails++;
                    $display("FAIL %s pair L=%h R=%h expected L=%h R=%h",
                             e.tag, left_o, right_o, e.l, e.r);
                end
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic put_bit(input logic ws, input logic d);
        @(negedge clk);
        bclk = 1'b0; wclk = ws; sdata = d;
        repeat (HB - 1) @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        repeat (HB - 1) @(negedge clk);
    endtask

    task automatic put_bits(input logic ws, input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) put_bit(ws, v[i]);
    endtask

    function automatic logic [31:0] slot(input logic [1:0] f, input logic [23:0] w);
        case (f)
            2'b00:   return {1'b1, w, 7'h7F};
            2'b01:   return {w, 8'hFF};
            2'b10:   return {16'hC3C3, w[15:0]};
            default: return {8'hFF, w};
        endcase
    endfunction

    function automatic logic [23:0] norm(input logic [1:0] f, input logic [23:0] w);
        if (f == 2'b10) return {{8{w[15]}}, w[15:0]};
        return w;
    endfunction

    task automatic start(input logic m, input logic c, input logic [1:0] f, input string tag);
        logic exp_byp, exp_slow;
        rst = 1'b1;
        cfg_mono = m; cfg_chsel = c; cfg_fmt = f;
        bclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        check(left_o == 24'h0 && right_o == 24'h0 && valid_o == 1'b0,
              $sformatf("R11 reset outputs L=%h R=%h V=%b expected 0 0 0", left_o, right_o, valid_o));
        exp_byp  = !m && c && (f == 2'b11);
        exp_slow = !m && c && !exp_byp;
        check(slow_o == exp_slow, $sformatf("R7 %s slow=%b expected %b", tag, slow_o, exp_slow));
        check(bypass_o == exp_byp, $sformatf("R9 %s bypass=%b expected %b", tag, bypass_o, exp_byp));
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run(input string tag);
        repeat (20) @(negedge clk);
        check(sb.size() == 0, $sformatf("R10 %s pending pairs=%0d expected 0", tag, sb.size()));
        sb.delete();
    endtask

    // frame-based run for the four framings (stereo or mono)
    task automatic run_framed(input logic m, input logic c, input logic [1:0] f,
                              input int n, input string tag);
        logic left_lvl;
        logic [23:0] l, r;
        exp_t e;
        start(m, c, f, tag);
        left_lvl = (f == 2'b00) ? 1'b0 : 1'b1;
        put_bits(!left_lvl, 32'h0, 32);
        for (int k = 0; k < n; k++) begin
            if (k == 0)      begin l = 24'h800000; r = 24'h7FFFFF; end
            else if (k == 1) begin l = 24'hFF8000; r = 24'h007FFF; end
            else             begin l = 24'($urandom); r = 24'($urandom); end
            e.tag = tag;
            if (!m)      begin e.l = norm(f, l); e.r = norm(f, r); end
            else if (!c) begin e.l = norm(f, l); e.r = norm(f, l); end
            else         begin e.l = norm(f, r); e.r = norm(f, r); end
            sb.push_back(e);
            put_bits(left_lvl, slot(f, l), 32);
            put_bits(!left_lvl, slot(f, r), 32);
        end
        if (f[1]) put_bits(left_lvl, 32'h0, 32);
        finish_run(tag);
    endtask

    task automatic run_bypass(input int n);
        logic [23:0] w;
        exp_t e;
        start(1'b0, 1'b1, 2'b11, "R9");
        put_bits(1'b0, 32'h0, 8);
        for (int k = 0; k < n; k++) begin
            w = (k == 0) ? 24'h800001 : 24'($urandom);
            e.l = w; e.r = w; e.tag = "R9 bypass";
            sb.push_back(e);
            put_bits(1'b0, 32'hFF, 8);
            put_bits(1'b1, {8'h0, w}, 24);
        end
        put_bits(1'b0, 32'hFF, 8);
        finish_run("R9");
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        run_framed(1'b0, 1'b0, 2'b00, 6, "R2 R6 I2S stereo");
        run_framed(1'b0, 1'b1, 2'b01, 6, "R1 R3 R7 left-justified slow");
        run_framed(1'b0, 1'b0, 2'b10, 6, "R5 R6 right-justified 16");
        run_framed(1'b0, 1'b0, 2'b11, 6, "R4 R6 right-justified 24");
        run_framed(1'b1, 1'b0, 2'b00, 4, "R8 mono left I2S");
        run_framed(1'b1, 1'b1, 2'b11, 4, "R8 mono right right-justified 24");
        run_framed(1'b1, 1'b1, 2'b01, 3, "R8 R7 mono right left-justified");
        run_bypass(6);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule